// File: doc/BRIEF.md
# Cache Maintenance Control Register Unit

This block is the single software-visible control word that steers maintenance of an instruction cache and its prefetch buffer. Software reads and writes it over a plain register bus. The block turns its command bits into hardware requests: a full or partial invalidation, and a one-time parity fault. It clears each command bit itself once the hardware has acted on it. The cache arrays, the prefetch datapath and the parity logic are not part of the block. It reaches them only through request and completion signals.

Four fields are implemented. A cache enable bit turns the cache on and off. Turning it off invalidates everything except the first prefetch slice, and the buffer then runs as one slice that is two entries deep. A manual invalidate bit requests a full invalidation. A coherency bit makes every flash programming event start a full invalidation. A fault-arm bit plants a single parity fault, which the next instruction access consumes; that access also raises a one-clock integrity event. While an invalidation is running, any further trigger is folded into it, so it never starts a second round.

Top module: `cache_maint_ctrl`

## Requirements
- R1: After reset the word at the register address reads 0x0000_8C01, which is enable (bit 15), manual invalidate (bit 11), coherency (bit 10) and fault-arm (bit 0) all set. `inval_req` and `cache_en` are 1 and `keep_first_slice` is 0.
- R2: Every bit other than 15, 11, 10 and 0 reads as 0 whatever is written. A read at any other address returns 0, and a write to any other address changes nothing.
- R3: A write with bit 11 set raises `inval_req` on the next clock, and bit 11 then reads 1. When `inval_done` is sampled, the following clock clears bit 11 and drops `inval_req`, provided nothing new was requested in that cycle.
- R4: A write of 0 to bit 11 or to bit 0 leaves that bit unchanged.
- R5: With bit 10 at 1, a `flash_evt` pulse raises `inval_req` on the next clock. With bit 10 at 0, `flash_evt` has no effect.
- R6: A completing invalidation clears bit 11 whatever started it, whether software or a flash event.
- R7: A write that clears bit 15 while it is 1 starts an invalidation, drives `cache_en` to 0 and `keep_first_slice` to 1. Writing bit 15 to 0 when it is already 0 starts nothing. Writing it to 1 restores `cache_en` = 1 and `keep_first_slice` = 0 and starts nothing.
- R8: Triggers that arrive while `inval_req` is high merge into the running invalidation. One `inval_done` ends it.
- R9: If `inval_done` and a write setting bit 11 fall in the same cycle, the set wins: `inval_req` stays 1 and bit 11 stays 1.
- R10: With bit 0 armed, an `access_strobe` cycle drives `fault_req` high in that same cycle and clears bit 0 at that clock edge. `integrity_evt` is then high for exactly the next cycle. Later accesses raise neither signal.
- R11: If a write setting bit 0 coincides with an access that consumes the armed fault, the fault fires and bit 0 remains armed.
- R12: Once `inval_req` is high it stays high until `inval_done` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read is addressed to the block |
| flash_evt | input | 1 | One-cycle flash programming event |
| inval_done | input | 1 | Completion from the cache and buffer invalidation logic |
| access_strobe | input | 1 | Instruction access strobe |
| cache_en | output | 1 | Cache and all prefetch slices enabled |
| inval_req | output | 1 | Invalidation request, held until completion |
| keep_first_slice | output | 1 | Invalidate everything but the first prefetch slice; run the buffer in basic mode |
| fault_req | output | 1 | One-shot parity fault request to the accessed line |
| integrity_evt | output | 1 | One-clock integrity error event |

## Verification
The sequencer is swept through all 32 combinations of five inputs: whether an invalidation is already running, the coherency setting, a flash event, a software set of bit 11, and the completion input, all applied in one cycle. Each combination has an arithmetically computed expected request and bit 11. The sweep separates a fresh start from a merge, a gated flash event from an honoured one, and completion from set-wins. Directed sequences cover the reset word, decoding of wrong addresses and unimplemented bits, ignored zero writes, both directions of the enable transition, and the single fault shot. The fault shot is tried with and without a simultaneous re-arm, which separates consumption from re-arming.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  // Field positions are software-visible and therefore fixed.
  localparam int unsigned POS_EN  = 15;
  localparam int unsigned POS_INV = 11;
  localparam int unsigned POS_COH = 10;
  localparam int unsigned POS_FLT = 0;

  // Decoded write strobe: hit plus the written value of each field.
  typedef struct packed {
    logic hit;
    logic en;
    logic inv;
    logic coh;
    logic flt;
  } cmc_wr_t;
endpackage

// File: rtl/cmc_rst_sync.sv
module cmc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cmc_regbank.sv
module cmc_regbank
  import cmc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h1E60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              manual_q,
  input  logic              armed_q,
  output logic [DATA_W-1:0] bus_rdata,
  output cmc_wr_t           wr,
  output logic              cache_en,
  output logic              coh_en,
  output logic              disable_evt
);
  logic addr_hit;
  logic en_q, en_d;
  logic coh_q, coh_d;
  logic unused_wdata;

  assign addr_hit = bus_sel && (bus_addr == REG_ADDR);
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    wr.hit = addr_hit && bus_wr;
    wr.en  = bus_wdata[POS_EN];
    wr.inv = bus_wdata[POS_INV];
    wr.coh = bus_wdata[POS_COH];
    wr.flt = bus_wdata[POS_FLT];
  end

  // Next-state of the plain read/write fields.
  always_comb begin
    en_d  = en_q;
    coh_d = coh_q;
    if (wr.hit) begin
      en_d  = wr.en;
      coh_d = wr.coh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b1;
      coh_q <= 1'b1;
    end else if (wr.hit) begin
      en_q  <= en_d;
      coh_q <= coh_d;
    end
  end

  // A 1 -> 0 transition of the enable starts a partial invalidation.
  assign disable_evt = wr.hit && en_q && !wr.en;
  assign cache_en    = en_q;
  assign coh_en      = coh_q;

  always_comb begin
    bus_rdata = '0;
    if (addr_hit && !bus_wr) begin
      bus_rdata[POS_EN]  = en_q;
      bus_rdata[POS_INV] = manual_q;
      bus_rdata[POS_COH] = coh_q;
      bus_rdata[POS_FLT] = armed_q;
    end
  end

  // R7: a write to the enable field holds its value afterwards.
  p_en_follows_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr.hit |=> (en_q == $past(wr.en)));
  // R2: a read not addressed to the block returns zero.
  p_idle_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> (bus_rdata == '0));
endmodule

// File: rtl/cmc_inval_seq.sv
module cmc_inval_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_manual,
  input  logic flash_evt,
  input  logic coh_en,
  input  logic disable_evt,
  input  logic inval_done,
  output logic inval_req,
  output logic manual_q
);
  logic busy_q, busy_d;
  logic manual_d;
  logic start;

  // Any trigger; while busy it merges into the running invalidation.
  assign start = set_manual || (flash_evt && coh_en) || disable_evt;

  always_comb begin
    busy_d   = start || (busy_q && !inval_done);
    manual_d = set_manual || (manual_q && !inval_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b1;
      manual_q <= 1'b1;
    end else begin
      busy_q   <= busy_d;
      manual_q <= manual_d;
    end
  end

  assign inval_req = busy_q;

  // R12: the request is held until completion is seen.
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_req && !inval_done) |=> inval_req);
  // R3: a pending manual bit always has a request behind it.
  p_manual_has_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    manual_q |-> inval_req);
  // R5: an honoured flash event raises the request.
  p_flash_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_evt && coh_en) |=> inval_req);
  // R8: one completion ends a merged invalidation when nothing new comes.
  p_single_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_req && inval_done && !start) |=> !inval_req);
  // R9: a set coinciding with completion keeps the bit.
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_manual && inval_done) |=> (manual_q && inval_req));
endmodule

// File: rtl/cmc_fault_arm.sv
module cmc_fault_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic set_flt,
  input  logic access_strobe,
  output logic fault_req,
  output logic integrity_evt,
  output logic armed_q
);
  logic armed_d;
  logic evt_q, evt_d;
  logic consume;

  assign consume = access_strobe && armed_q;

  always_comb begin
    armed_d = set_flt || (armed_q && !access_strobe);
    evt_d   = consume;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      evt_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      evt_q   <= evt_d;
    end
  end

  assign fault_req     = consume;
  assign integrity_evt = evt_q;

  // R10: the event follows exactly a consuming access.
  p_evt_after_consume_r10: assert property (@(posedge clk) disable iff (!rst_n)
    integrity_evt |-> $past(fault_req));
  // R10: without a re-arm, a consumed fault is gone.
  p_fault_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_req && !set_flt) |=> !armed_q);
  // R11: re-arm in the consuming cycle survives.
  p_rearm_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_flt |=> armed_q);
endmodule

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl
  import cmc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h1E60,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              flash_evt,
  input  logic              inval_done,
  input  logic              access_strobe,
  output logic              cache_en,
  output logic              inval_req,
  output logic              keep_first_slice,
  output logic              fault_req,
  output logic              integrity_evt
);
  logic    rst_sync_n;
  cmc_wr_t wr;
  logic    coh_en;
  logic    disable_evt;
  logic    manual_q;
  logic    armed_q;

  cmc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cmc_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_regbank (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .manual_q    (manual_q),
    .armed_q     (armed_q),
    .bus_rdata   (bus_rdata),
    .wr          (wr),
    .cache_en    (cache_en),
    .coh_en      (coh_en),
    .disable_evt (disable_evt)
  );

  cmc_inval_seq u_inval_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .set_manual  (wr.hit && wr.inv),
    .flash_evt   (flash_evt),
    .coh_en      (coh_en),
    .disable_evt (disable_evt),
    .inval_done  (inval_done),
    .inval_req   (inval_req),
    .manual_q    (manual_q)
  );

  cmc_fault_arm u_fault_arm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .set_flt       (wr.hit && wr.flt),
    .access_strobe (access_strobe),
    .fault_req     (fault_req),
    .integrity_evt (integrity_evt),
    .armed_q       (armed_q)
  );

  assign keep_first_slice = !cache_en;

  // R7: turning the cache off requests a partial invalidation.
  p_disable_starts_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && bus_wr && (bus_addr == REG_ADDR) && cache_en && !bus_wdata[POS_EN])
      |=> (inval_req && keep_first_slice));
  // R6: completion without a new manual set clears the manual bit.
  p_done_clears_manual_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (inval_done && !(bus_sel && bus_wr && (bus_addr == REG_ADDR) && bus_wdata[POS_INV]))
      |=> !manual_q);
endmodule

// File: tb/cache_maint_ctrl_tb.sv
module cache_maint_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        flash_evt, inval_done, access_strobe;
  logic        cache_en, inval_req, keep_first_slice, fault_req, integrity_evt;

  localparam logic [15:0] A = 16'h1E60;
  int checks = 0;
  int errors = 0;
  bit done_flag = 0;
  logic last_fault;
  logic [31:0] rd;

  always #10 clk = ~clk;

  cache_maint_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flash_evt(flash_evt), .inval_done(inval_done), .access_strobe(access_strobe),
    .cache_en(cache_en), .inval_req(inval_req), .keep_first_slice(keep_first_slice),
    .fault_req(fault_req), .integrity_evt(integrity_evt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // One clock: inputs applied at negedge, registered results visible after #1.
  task automatic step(input logic w, input logic [15:0] ad, input logic [31:0] wd,
                      input logic fl, input logic dn, input logic acc);
    @(negedge clk);
    bus_sel = w; bus_wr = w; bus_addr = ad; bus_wdata = wd;
    flash_evt = fl; inval_done = dn; access_strobe = acc;
    #1 last_fault = fault_req;
    @(posedge clk);
    #1;
    bus_sel = 0; bus_wr = 0; flash_evt = 0; inval_done = 0; access_strobe = 0;
  endtask

  task automatic rd_reg(input logic [15:0] ad, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = ad;
    #1 v = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) if (inval_req) step(0, A, 0, 0, 1, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    flash_evt = 0; inval_done = 0; access_strobe = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    rd_reg(A, rd);
    check("R1 reset word", rd, 32'h0000_8C01);
    check("R1 inval_req", {31'b0, inval_req}, 1);
    check("R1 cache_en", {31'b0, cache_en}, 1);
    check("R1 keep_first_slice", {31'b0, keep_first_slice}, 0);
    // R4: zero writes to self-clearing bits ignored
    step(1, A, 32'h0000_8400, 0, 0, 0);
    rd_reg(A, rd);
    check("R4 zero write ignored", rd, 32'h0000_8C01);
    // R3/R6: completion clears the manual bit
    step(0, A, 0, 0, 1, 0);
    rd_reg(A, rd);
    check("R3 bit11 cleared on done", rd, 32'h0000_8401);
    check("R3 req dropped", {31'b0, inval_req}, 0);
    // R2: other address and unimplemented bits
    rd_reg(16'h1E64, rd);
    check("R2 other addr reads 0", rd, 0);
    step(1, 16'h1E64, 32'h0, 0, 0, 0);
    rd_reg(A, rd);
    check("R2 other addr write ignored", rd, 32'h0000_8401);
    check("R2 no req from stray write", {31'b0, inval_req}, 0);
    step(1, A, 32'hFFFF_FFFF, 0, 0, 0);
    rd_reg(A, rd);
    check("R2 unimplemented bits zero", rd, 32'h0000_8C01);
    check("R3 manual set raises req", {31'b0, inval_req}, 1);
    // R8: merged triggers, single completion
    step(0, A, 0, 1, 0, 0);
    step(1, A, 32'h0000_8C00, 0, 0, 0);
    check("R12 req held", {31'b0, inval_req}, 1);
    step(0, A, 0, 0, 1, 0);
    check("R8 single done ends merged", {31'b0, inval_req}, 0);
    // R5/R6/R9 sweep over prebusy, coh, flash, set, done
    for (int pb = 0; pb < 2; pb++)
      for (int co = 0; co < 2; co++)
        for (int fl = 0; fl < 2; fl++)
          for (int ws = 0; ws < 2; ws++)
            for (int dn = 0; dn < 2; dn++) begin
              logic er, em;
              drain();
              step(1, A, 32'h8000 | (32'(co) << 10) | (32'(pb) << 11), 0, 0, 0);
              step(ws[0], A, 32'h8000 | (32'(co) << 10) | 32'h800, fl[0], dn[0], 0);
              er = ws[0] | (fl[0] & co[0]) | (pb[0] & !dn[0]);
              em = ws[0] | (pb[0] & !dn[0]);
              rd_reg(A, rd);
              check($sformatf("R5/R9 sweep req pb%0d c%0d f%0d s%0d d%0d", pb, co, fl, ws, dn),
                    {31'b0, inval_req}, {31'b0, er});
              check($sformatf("R6/R9 sweep bit11 pb%0d c%0d f%0d s%0d d%0d", pb, co, fl, ws, dn),
                    {31'b0, rd[11]}, {31'b0, em});
            end
    drain();
    // R7: disable/enable
    step(1, A, 32'h0000_0400, 0, 0, 0);
    check("R7 disable starts inval", {31'b0, inval_req}, 1);
    check("R7 cache_en low", {31'b0, cache_en}, 0);
    check("R7 keep_first high", {31'b0, keep_first_slice}, 1);
    drain();
    step(1, A, 32'h0000_0400, 0, 0, 0);
    check("R7 repeated zero no inval", {31'b0, inval_req}, 0);
    step(1, A, 32'h0000_8400, 0, 0, 0);
    check("R7 enable no inval", {31'b0, inval_req}, 0);
    check("R7 cache_en restored", {31'b0, cache_en}, 1);
    check("R7 keep_first low", {31'b0, keep_first_slice}, 0);
    // R10: single fault shot (still armed from reset)
    rd_reg(A, rd);
    check("R10 armed before access", {31'b0, rd[0]}, 1);
    step(0, A, 0, 0, 0, 1);
    check("R10 fault_req in access cycle", {31'b0, last_fault}, 1);
    check("R10 integrity_evt next cycle", {31'b0, integrity_evt}, 1);
    rd_reg(A, rd);
    check("R10 arm cleared", {31'b0, rd[0]}, 0);
    step(0, A, 0, 0, 0, 1);
    check("R10 no second fault", {31'b0, last_fault}, 0);
    check("R10 integrity_evt one cycle", {31'b0, integrity_evt}, 0);
    // R11: re-arm coinciding with consumption
    step(1, A, 32'h0000_8401, 0, 0, 0);
    step(1, A, 32'h0000_8401, 0, 0, 1);
    check("R11 fault fires", {31'b0, last_fault}, 1);
    rd_reg(A, rd);
    check("R11 stays armed", {31'b0, rd[0]}, 1);
    step(0, A, 0, 0, 0, 1);
    check("R11 re-armed fault fires", {31'b0, last_fault}, 1);
    finish_run();
  end
endmodule